// File: doc/BRIEF.md
# Outstanding Miss Tracking Table

This block keeps a small, fully associative table of line addresses that have a transaction in flight below a second-level cache controller. Each occupied slot records the line's transient state, a dirty flag, a bit vector of the core ports waiting for data and a counter of atomic operations forwarded downstream and not yet answered. The controller drives one command per cycle: allocate or join, update, count up, count down, deliver fill, or take a write-back acknowledge. A separate port pops completion triggers. A lookup port answers combinationally for any address.

Repeated read misses to one line are folded into a single downstream read. The registered `rsp_down_rd` pulse tells the controller when to send one. When the atomic counter of a line drains to zero, the block posts a completion trigger for that line. Popping the trigger either retires the line or, if new atomics have arrived since, keeps it.

Top module: `mtt_table`

## Requirements
- R1: After reset no slot is occupied, and `full`, `trig_valid`, `rsp_down_rd`, `rsp_err`, `evt_inv` and `rsp_fanout` are all low.
- R2: An allocate (`cmd_op`=1) of an address that is not present takes the lowest-numbered free slot. It stores `cmd_state` and `cmd_dirty`, starts with an empty requester vector and a zero count, and then adds the requester when the kind is read or atomic.
- R3: Requester kinds are coded 0 read, 1 atomic, 2 and 3 write. A write-kind allocate never sets a requester bit.
- R4: One cycle after a read-kind allocate, `rsp_down_rd` is high exactly when the line's requester vector then holds a single bit. A second reader of the same line only joins the vector.
- R5: Allocating an address that is already present changes neither its state nor its dirty flag, only its requester vector. No second slot is taken.
- R6: Count-up (`cmd_op`=3) raises a present line's atomic counter by one, and count-down (`cmd_op`=4) lowers it by one. Update (`cmd_op`=2) rewrites the state and dirty flag.
- R7: A count-down that reaches zero posts a trigger. `trig_valid` is then high and `trig_addr` shows the pending line in the lowest-numbered slot.
- R8: A count-down at zero, or a count-up at the maximum count, pulses `rsp_err` one cycle later and leaves the counter unchanged.
- R9: Popping a trigger (`trig_pop`, with no command in the same cycle) frees the line and pulses `evt_inv` one cycle later if its count is zero. Otherwise the line stays and only the trigger is withdrawn.
- R10: The lookup state is the slot's state when the address is present, and `lk_tag_state` otherwise.
- R11: A fill (`cmd_op`=5) drives the line's requester vector on `rsp_fanout` one cycle later and frees the line. A write-back acknowledge (`cmd_op`=6) frees it with `rsp_fanout` zero.
- R12: `full` is high while every slot is occupied. An allocate of a new address while full has no effect.
- R13: Update, count, fill and acknowledge commands to an address that is not present have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code: 1 allocate, 2 update, 3 count up, 4 count down, 5 fill, 6 write-back ack |
| cmd_kind | input | 2 | Requester kind for allocate |
| cmd_addr | input | ADDR_W | Line address of the command |
| cmd_req | input | clog2(N_REQ) | Requesting core port |
| cmd_state | input | ST_W | State written on allocate or update |
| cmd_dirty | input | 1 | Dirty flag written on allocate or update |
| trig_pop | input | 1 | Consume the presented trigger |
| lk_addr | input | ADDR_W | Lookup address |
| lk_tag_state | input | ST_W | State from the cache tag for the lookup address |
| full | output | 1 | All slots occupied |
| rsp_down_rd | output | 1 | Issue a downstream read for the last allocate |
| rsp_fanout | output | N_REQ | Ports to receive fill data |
| rsp_err | output | 1 | Counter underflow or overflow |
| evt_inv | output | 1 | Popped line retired to invalid |
| trig_valid | output | 1 | A completion trigger is pending |
| trig_addr | output | ADDR_W | Address of the presented trigger |
| lk_hit | output | 1 | Lookup address is present |
| lk_state | output | ST_W | Effective state of the lookup address |
| lk_dirty | output | 1 | Dirty flag of the hit slot |
| lk_reqs | output | N_REQ | Requester vector of the hit slot |
| lk_cnt | output | CNT_W | Atomic counter of the hit slot |

## Verification
The assertions assume that `trig_pop` is raised only while a trigger is presented and never in the same cycle as a command, so that retiring a line and a command never contend for one slot. The stimulus enforces this. It pops only when its own model holds a pending trigger, and otherwise it issues a command. Commands draw from a pool of six addresses for four slots, so that joins, the full condition, commands to absent lines and counter limits all occur.

// File: rtl/mtt_pkg.sv
package mtt_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ALLOC  = 3'd1,
    OP_UPDATE = 3'd2,
    OP_INC    = 3'd3,
    OP_DEC    = 3'd4,
    OP_FILL   = 3'd5,
    OP_WBACK  = 3'd6
  } mtt_op_e;

  typedef enum logic [1:0] {
    RK_READ   = 2'd0,
    RK_ATOMIC = 2'd1,
    RK_WRITE  = 2'd2,
    RK_WRITE2 = 2'd3
  } mtt_kind_e;
endpackage

// File: rtl/mtt_rst_sync.sv
module mtt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sn = s2_q;
endmodule

// File: rtl/mtt_prio.sv
// Lowest-index-first selector over a request vector.
module mtt_prio #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/mtt_match.sv
// Fully associative compare of one key against all slot tags.
module mtt_match #(
  parameter int N  = 4,
  parameter int AW = 16,
  parameter int IW = 2
) (
  input  logic [N-1:0]         vld,
  input  logic [N-1:0][AW-1:0] tags,
  input  logic [AW-1:0]        key,
  output logic [N-1:0]         hit_oh,
  output logic                 hit,
  output logic [IW-1:0]        idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_oh[g] = vld[g] && (tags[g] == key);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_oh[i]) idx = idx | IW'(i);
    end
  end

  assign hit = |hit_oh;
endmodule

// File: rtl/mtt_entry.sv
// One tracking slot: tag, transient state, requesters, atomic counter.
module mtt_entry #(
  parameter int AW    = 16,
  parameter int NR    = 4,
  parameter int CNT_W = 4,
  parameter int ST_W  = 3
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             alloc_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [ST_W-1:0]  state_i,
  input  logic             dirty_i,
  input  logic             upd_i,
  input  logic             join_i,
  input  logic [NR-1:0]    join_mask_i,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             free_i,
  input  logic             tclr_i,
  output logic             vld_o,
  output logic [AW-1:0]    addr_o,
  output logic [ST_W-1:0]  state_o,
  output logic             dirty_o,
  output logic [NR-1:0]    reqs_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pend_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             vld_q, vld_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [ST_W-1:0]  st_q, st_d;
  logic             dirty_q, dirty_d;
  logic [NR-1:0]    reqs_q, reqs_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             en;

  assign en = alloc_i | upd_i | join_i | inc_i | dec_i | free_i | tclr_i;

  always_comb begin
    vld_d   = vld_q;
    addr_d  = addr_q;
    st_d    = st_q;
    dirty_d = dirty_q;
    reqs_d  = reqs_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    if (alloc_i) begin
      vld_d   = 1'b1;
      addr_d  = addr_i;
      st_d    = state_i;
      dirty_d = dirty_i;
      reqs_d  = '0;
      cnt_d   = '0;
      pend_d  = 1'b0;
    end
    if (join_i) reqs_d = reqs_d | join_mask_i;
    if (upd_i) begin
      st_d    = state_i;
      dirty_d = dirty_i;
    end
    if (inc_i && (cnt_q != CNT_MAX)) cnt_d = cnt_q + 1'b1;
    if (dec_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) pend_d = 1'b1;
    end
    if (tclr_i) pend_d = 1'b0;
    if (free_i) begin
      vld_d  = 1'b0;
      reqs_d = '0;
      cnt_d  = '0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      vld_q   <= 1'b0;
      addr_q  <= '0;
      st_q    <= '0;
      dirty_q <= 1'b0;
      reqs_q  <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else if (en) begin
      vld_q   <= vld_d;
      addr_q  <= addr_d;
      st_q    <= st_d;
      dirty_q <= dirty_d;
      reqs_q  <= reqs_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
    end
  end

  assign vld_o   = vld_q;
  assign addr_o  = addr_q;
  assign state_o = st_q;
  assign dirty_o = dirty_q;
  assign reqs_o  = reqs_q;
  assign cnt_o   = cnt_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/mtt_table.sv
module mtt_table
  import mtt_pkg::*;
#(
  parameter int N_ENT  = 4,
  parameter int N_REQ  = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 4,
  parameter int ST_W   = 3,
  localparam int IW    = $clog2(N_ENT),
  localparam int RW    = $clog2(N_REQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [RW-1:0]     cmd_req,
  input  logic [ST_W-1:0]   cmd_state,
  input  logic              cmd_dirty,
  input  logic              trig_pop,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [ST_W-1:0]   lk_tag_state,
  output logic              full,
  output logic              rsp_down_rd,
  output logic [N_REQ-1:0]  rsp_fanout,
  output logic              rsp_err,
  output logic              evt_inv,
  output logic              trig_valid,
  output logic [ADDR_W-1:0] trig_addr,
  output logic              lk_hit,
  output logic [ST_W-1:0]   lk_state,
  output logic              lk_dirty,
  output logic [N_REQ-1:0]  lk_reqs,
  output logic [CNT_W-1:0]  lk_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic rst_sn;
  mtt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  // slot contents
  logic [N_ENT-1:0]              e_vld, e_dirty, e_pend;
  logic [N_ENT-1:0][ADDR_W-1:0]  e_addr;
  logic [N_ENT-1:0][ST_W-1:0]    e_state;
  logic [N_ENT-1:0][N_REQ-1:0]   e_reqs;
  logic [N_ENT-1:0][CNT_W-1:0]   e_cnt;

  // command decode
  mtt_op_e   op;
  mtt_kind_e kind;
  logic is_alloc, is_upd, is_inc, is_dec, is_fill, is_wback;

  assign op       = mtt_op_e'(cmd_op);
  assign kind     = mtt_kind_e'(cmd_kind);
  assign is_alloc = cmd_valid && (op == OP_ALLOC);
  assign is_upd   = cmd_valid && (op == OP_UPDATE);
  assign is_inc   = cmd_valid && (op == OP_INC);
  assign is_dec   = cmd_valid && (op == OP_DEC);
  assign is_fill  = cmd_valid && (op == OP_FILL);
  assign is_wback = cmd_valid && (op == OP_WBACK);

  // command-side match and free slot
  logic [N_ENT-1:0] c_hit_oh;
  logic             c_hit;
  logic [IW-1:0]    c_idx;
  logic             free_any;
  logic [IW-1:0]    free_idx;

  mtt_match #(.N(N_ENT), .AW(ADDR_W), .IW(IW)) u_cmatch (
    .vld(e_vld), .tags(e_addr), .key(cmd_addr),
    .hit_oh(c_hit_oh), .hit(c_hit), .idx(c_idx)
  );

  mtt_prio #(.N(N_ENT), .IW(IW)) u_free (
    .req(~e_vld), .any(free_any), .idx(free_idx)
  );

  assign full = ~free_any;

  logic             alloc_new, tgt_ok, do_join;
  logic [IW-1:0]    tgt_idx;
  logic [N_REQ-1:0] join_mask, reqs_after;
  logic [CNT_W-1:0] c_cnt;

  assign alloc_new  = is_alloc && !c_hit && free_any;
  assign tgt_ok     = (is_alloc && c_hit) || alloc_new;
  assign tgt_idx    = c_hit ? c_idx : free_idx;
  assign do_join    = tgt_ok && ((kind == RK_READ) || (kind == RK_ATOMIC));
  assign join_mask  = N_REQ'(1) << cmd_req;
  assign reqs_after = (c_hit ? e_reqs[c_idx] : '0) | (do_join ? join_mask : '0);
  assign c_cnt      = e_cnt[c_idx];

  // trigger selection
  logic          t_any, pop_ok;
  logic [IW-1:0] t_idx;

  mtt_prio #(.N(N_ENT), .IW(IW)) u_trig (
    .req(e_pend), .any(t_any), .idx(t_idx)
  );

  assign pop_ok     = trig_pop && t_any;
  assign trig_valid = t_any;
  assign trig_addr  = e_addr[t_idx];

  // slots
  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic on_tgt, on_hit, on_pop;
    assign on_tgt = tgt_ok && (tgt_idx == IW'(g));
    assign on_hit = c_hit && (c_idx == IW'(g));
    assign on_pop = pop_ok && (t_idx == IW'(g));

    mtt_entry #(.AW(ADDR_W), .NR(N_REQ), .CNT_W(CNT_W), .ST_W(ST_W)) u_ent (
      .clk(clk),
      .rst_sn(rst_sn),
      .alloc_i(alloc_new && (free_idx == IW'(g))),
      .addr_i(cmd_addr),
      .state_i(cmd_state),
      .dirty_i(cmd_dirty),
      .upd_i(is_upd && on_hit),
      .join_i(do_join && on_tgt),
      .join_mask_i(join_mask),
      .inc_i(is_inc && on_hit),
      .dec_i(is_dec && on_hit),
      .free_i(((is_fill || is_wback) && on_hit) || (on_pop && (e_cnt[g] == '0))),
      .tclr_i(on_pop),
      .vld_o(e_vld[g]),
      .addr_o(e_addr[g]),
      .state_o(e_state[g]),
      .dirty_o(e_dirty[g]),
      .reqs_o(e_reqs[g]),
      .cnt_o(e_cnt[g]),
      .pend_o(e_pend[g])
    );
  end

  // registered responses
  logic             down_d, err_d, inv_d;
  logic [N_REQ-1:0] fan_d;

  always_comb begin
    down_d = is_alloc && (kind == RK_READ) && tgt_ok && ($countones(reqs_after) == 1);
    err_d  = c_hit && ((is_dec && (c_cnt == '0)) || (is_inc && (c_cnt == CNT_MAX)));
    fan_d  = (is_fill && c_hit) ? e_reqs[c_idx] : '0;
    inv_d  = pop_ok && (e_cnt[t_idx] == '0);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rsp_down_rd <= 1'b0;
      rsp_err     <= 1'b0;
      rsp_fanout  <= '0;
      evt_inv     <= 1'b0;
    end else begin
      rsp_down_rd <= down_d;
      rsp_err     <= err_d;
      rsp_fanout  <= fan_d;
      evt_inv     <= inv_d;
    end
  end

  // lookup port
  logic [N_ENT-1:0] l_hit_oh;
  logic [IW-1:0]    l_idx;

  mtt_match #(.N(N_ENT), .AW(ADDR_W), .IW(IW)) u_lmatch (
    .vld(e_vld), .tags(e_addr), .key(lk_addr),
    .hit_oh(l_hit_oh), .hit(lk_hit), .idx(l_idx)
  );

  assign lk_state = lk_hit ? e_state[l_idx] : lk_tag_state;
  assign lk_dirty = lk_hit && e_dirty[l_idx];
  assign lk_reqs  = lk_hit ? e_reqs[l_idx] : '0;
  assign lk_cnt   = lk_hit ? e_cnt[l_idx] : '0;
endmodule

// File: rtl/mtt_checker.sv
module mtt_checker
  import mtt_pkg::*;
#(
  parameter int N_ENT = 4,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic [1:0]       cmd_kind,
  input logic             trig_pop,
  input logic             trig_valid,
  input logic             full,
  input logic             cmd_hit,
  input logic [N_ENT-1:0] hit_oh,
  input logic [N_ENT-1:0] ent_vld,
  input logic [CNT_W-1:0] hit_cnt,
  input logic             rsp_down_rd,
  input logic             rsp_err,
  input logic             evt_inv
);
  // input rule: pops only with a trigger shown and no command alongside (R9)
  p_pop_legal_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    trig_pop |-> (trig_valid && !cmd_valid));

  p_unique_match_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(hit_oh));

  p_full_hold_r12: assert property (@(posedge clk) disable iff (!rst_sn)
    (full && cmd_valid && (cmd_op == OP_ALLOC) && !cmd_hit) |=> $stable(ent_vld));

  p_down_src_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    rsp_down_rd |-> $past(cmd_valid && (cmd_op == OP_ALLOC) && (cmd_kind == RK_READ)));

  p_err_src_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    rsp_err |-> $past(cmd_valid && ((cmd_op == OP_INC) || (cmd_op == OP_DEC))));

  p_fill_free_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    (cmd_valid && (cmd_op == OP_FILL) && cmd_hit) |=>
      ($countones(ent_vld) == $past($countones(ent_vld)) - 1));

  p_drain_trig_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (cmd_valid && (cmd_op == OP_DEC) && cmd_hit && (hit_cnt == CNT_W'(1))) |=> trig_valid);

  p_inv_src_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    evt_inv |-> $past(trig_pop));
endmodule

bind mtt_table mtt_checker #(.N_ENT(N_ENT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_kind(cmd_kind), .trig_pop(trig_pop), .trig_valid(trig_valid),
  .full(full), .cmd_hit(c_hit), .hit_oh(c_hit_oh), .ent_vld(e_vld),
  .hit_cnt(c_cnt), .rsp_down_rd(rsp_down_rd), .rsp_err(rsp_err),
  .evt_inv(evt_inv)
);

// File: tb/sim_mtt_table.sv
`timescale 1ns/100ps
module sim_mtt_table;
  localparam int NE = 4, NR = 4, AW = 16, CW = 4, SW = 3, RW = 2;
  localparam int NPOOL = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_dirty, trig_pop;
  logic [2:0] cmd_op;
  logic [1:0] cmd_kind;
  logic [AW-1:0] cmd_addr, lk_addr;
  logic [RW-1:0] cmd_req;
  logic [SW-1:0] cmd_state, lk_tag_state;
  logic full, rsp_down_rd, rsp_err, evt_inv, trig_valid, lk_hit, lk_dirty;
  logic [NR-1:0] rsp_fanout, lk_reqs;
  logic [AW-1:0] trig_addr;
  logic [SW-1:0] lk_state;
  logic [CW-1:0] lk_cnt;

  always #2 clk = ~clk;

  mtt_table u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_req(cmd_req),
    .cmd_state(cmd_state), .cmd_dirty(cmd_dirty), .trig_pop(trig_pop),
    .lk_addr(lk_addr), .lk_tag_state(lk_tag_state), .full(full),
    .rsp_down_rd(rsp_down_rd), .rsp_fanout(rsp_fanout), .rsp_err(rsp_err),
    .evt_inv(evt_inv), .trig_valid(trig_valid), .trig_addr(trig_addr),
    .lk_hit(lk_hit), .lk_state(lk_state), .lk_dirty(lk_dirty),
    .lk_reqs(lk_reqs), .lk_cnt(lk_cnt)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model of the table
  bit          m_v[NE];
  int          m_a[NE];
  int          m_s[NE];
  bit          m_d[NE];
  int          m_r[NE];
  int          m_c[NE];
  bit          m_p[NE];

  function automatic int pool(int i);
    return 16'h1000 + i * 16'h40;
  endfunction

  function automatic int m_find(int a);
    for (int i = 0; i < NE; i++) if (m_v[i] && m_a[i] == a) return i;
    return -1;
  endfunction

  function automatic int m_first_free();
    for (int i = 0; i < NE; i++) if (!m_v[i]) return i;
    return -1;
  endfunction

  function automatic int m_first_pend();
    for (int i = 0; i < NE; i++) if (m_p[i]) return i;
    return -1;
  endfunction

  function automatic int pop4(int v);
    return (v & 1) + ((v >> 1) & 1) + ((v >> 2) & 1) + ((v >> 3) & 1);
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic sweep(string tag);
    int fp;
    bit all;
    all = 1;
    for (int i = 0; i < NE; i++) all &= m_v[i];
    check(tag, "full", int'(full), int'(all));
    fp = m_first_pend();
    check(tag, "trig_valid", int'(trig_valid), int'(fp >= 0));
    if (fp >= 0) check(tag, "trig_addr", int'(trig_addr), m_a[fp]);
    for (int k = 0; k < NPOOL; k++) begin
      int ix, ts;
      ts = int'($urandom_range(7, 0));
      lk_addr = AW'(pool(k));
      lk_tag_state = SW'(ts);
      #0.2;
      ix = m_find(pool(k));
      check(tag, "lk_hit", int'(lk_hit), int'(ix >= 0));
      check(tag, "lk_state", int'(lk_state), (ix >= 0) ? m_s[ix] : ts);
      if (ix >= 0) begin
        check(tag, "lk_dirty", int'(lk_dirty), int'(m_d[ix]));
        check(tag, "lk_reqs", int'(lk_reqs), m_r[ix]);
        check(tag, "lk_cnt", int'(lk_cnt), m_c[ix]);
      end
    end
  endtask

  task automatic step_cmd(string tag, int op, int a, int kind, int req, int st, int d);
    int ix, e_down, e_fan, e_err;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'(op); cmd_addr = AW'(a); cmd_kind = 2'(kind);
    cmd_req = RW'(req); cmd_state = SW'(st); cmd_dirty = d[0];
    e_down = 0; e_fan = 0; e_err = 0;
    ix = m_find(a);
    case (op)
      1: begin
        if (ix < 0) begin
          ix = m_first_free();
          if (ix >= 0) begin
            m_v[ix] = 1; m_a[ix] = a; m_s[ix] = st; m_d[ix] = d[0];
            m_r[ix] = 0; m_c[ix] = 0; m_p[ix] = 0;
          end
        end
        if (ix >= 0 && kind < 2) m_r[ix] |= (1 << req);
        if (ix >= 0 && kind == 0 && pop4(m_r[ix]) == 1) e_down = 1;
      end
      2: if (ix >= 0) begin m_s[ix] = st; m_d[ix] = d[0]; end
      3: if (ix >= 0) begin
        if (m_c[ix] == CMAX) e_err = 1; else m_c[ix]++;
      end
      4: if (ix >= 0) begin
        if (m_c[ix] == 0) e_err = 1;
        else begin m_c[ix]--; if (m_c[ix] == 0) m_p[ix] = 1; end
      end
      5: if (ix >= 0) begin e_fan = m_r[ix]; m_v[ix] = 0; m_p[ix] = 0; end
      6: if (ix >= 0) begin m_v[ix] = 0; m_p[ix] = 0; end
      default: ;
    endcase
    @(posedge clk);
    #0.3;
    cmd_valid = 0;
    check(tag, "rsp_down_rd", int'(rsp_down_rd), e_down);
    check(tag, "rsp_fanout", int'(rsp_fanout), e_fan);
    check(tag, "rsp_err", int'(rsp_err), e_err);
    check(tag, "evt_inv", int'(evt_inv), 0);
    sweep(tag);
  endtask

  task automatic step_pop(string tag);
    int ix, e_inv;
    @(negedge clk);
    trig_pop = 1;
    ix = m_first_pend();
    e_inv = 0;
    if (ix >= 0) begin
      if (m_c[ix] == 0) begin e_inv = 1; m_v[ix] = 0; end
      m_p[ix] = 0;
    end
    @(posedge clk);
    #0.3;
    trig_pop = 0;
    check(tag, "evt_inv", int'(evt_inv), e_inv);
    check(tag, "rsp_err", int'(rsp_err), 0);
    sweep(tag);
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    int sd;
    sd = int'($urandom(32'h5eed_0042));
    rst_n = 0; cmd_valid = 0; trig_pop = 0; cmd_op = 0; cmd_kind = 0;
    cmd_addr = 0; cmd_req = 0; cmd_state = 0; cmd_dirty = 0;
    lk_addr = 0; lk_tag_state = 0;
    for (int i = 0; i < NE; i++) begin
      m_v[i] = 0; m_a[i] = 0; m_s[i] = 0; m_d[i] = 0; m_r[i] = 0; m_c[i] = 0; m_p[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #0.3;
    // R1 reset state
    check("R1", "rsp_down_rd", int'(rsp_down_rd), 0);
    check("R1", "rsp_err", int'(rsp_err), 0);
    check("R1", "evt_inv", int'(evt_inv), 0);
    check("R1", "rsp_fanout", int'(rsp_fanout), 0);
    sweep("R1");

    // R2 / R4: first reader allocates and needs a downstream read
    step_cmd("R2", 1, pool(0), 0, 0, 3, 1);
    // R5 / R4: second reader joins, state kept, no new read
    step_cmd("R5", 1, pool(0), 0, 2, 5, 0);
    step_cmd("R4", 1, pool(0), 0, 0, 1, 0);
    // R3: writer does not join
    step_cmd("R3", 1, pool(0), 2, 3, 1, 0);
    // R10 exercised in every sweep; R6 update
    step_cmd("R6", 2, pool(0), 0, 0, 6, 0);
    // R11: fill fans out and frees
    step_cmd("R11", 5, pool(0), 0, 0, 0, 0);
    check("R11", "fill freed", int'(m_find(pool(0))), -1);
    // R6/R7/R8/R9: atomics on line 1
    step_cmd("R2", 1, pool(1), 1, 1, 2, 0);
    step_cmd("R6", 3, pool(1), 0, 0, 0, 0);
    step_cmd("R6", 3, pool(1), 0, 0, 0, 0);
    step_cmd("R6", 4, pool(1), 0, 0, 0, 0);
    step_cmd("R7", 4, pool(1), 0, 0, 0, 0);
    step_cmd("R8", 4, pool(1), 0, 0, 0, 0);
    step_cmd("R6", 3, pool(1), 0, 0, 0, 0);
    step_pop("R9");
    step_cmd("R7", 4, pool(1), 0, 0, 0, 0);
    step_pop("R9");
    // R13: commands to an absent line
    step_cmd("R13", 3, pool(2), 0, 0, 0, 0);
    step_cmd("R13", 4, pool(2), 0, 0, 0, 0);
    step_cmd("R13", 2, pool(2), 0, 0, 7, 1);
    step_cmd("R13", 5, pool(2), 0, 0, 0, 0);
    // R12: fill the table, then try a fifth line
    for (int k = 0; k < NE; k++) step_cmd("R12", 1, pool(k), k % 3, k, k, k & 1);
    step_cmd("R12", 1, pool(5), 0, 1, 4, 1);
    step_cmd("R11", 6, pool(2), 0, 0, 0, 0);
    // R8: counter saturation
    for (int k = 0; k < CMAX + 1; k++) step_cmd("R8", 3, pool(0), 0, 0, 0, 0);

    // constrained random mix
    for (int n = 0; n < 800; n++) begin
      if (m_first_pend() >= 0 && $urandom_range(3, 0) == 0)
        step_pop("R9");
      else
        step_cmd("R2", int'($urandom_range(6, 1)), pool(int'($urandom_range(NPOOL - 1, 0))),
                 int'($urandom_range(3, 0)), int'($urandom_range(NR - 1, 0)),
                 int'($urandom_range(7, 0)), int'($urandom_range(1, 0)));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule